// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

This block gathers a fixed set of peripheral interrupt request lines and decides whether the processor core should be interrupted. Each source has a pending flag and a 3-bit level. A request event sets the pending flag. Software can clear a pending flag and program a level through a small write port.

On every clock the arbiter applies three gates to each source: the global enable, the pending flag, and a level strictly above the core's current priority level (IPL). Among the sources that pass, it picks the one with the highest level. When several share that level, the lowest index wins. The result is registered: a valid flag, the winning index and its level.

When the core acknowledges, the pending flag of the presented source is cleared. Vector fetch and context saving are left to the core.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `gie` is 0 when sampled at a clock edge, `req_valid` is 0 after that edge, whatever the levels and pending flags.
- R2: A 1 on `irq_evt[i]` at a clock edge sets the pending flag of source i. If source i is then eligible, it is presented after that same edge.
- R3: A write with `cfg_pend_we`=1 and `cfg_pend_val`=0 clears the pending flag of source `cfg_idx`. With `cfg_pend_val`=1 the write has no effect and never sets the flag.
- R4: Level code 0 disables a source. Codes 1 to 7 are levels 1 to 7, and 7 is the highest. A source can only be presented with a non-zero level.
- R5: A source is eligible only when its level is strictly greater than `ipl`. An `ipl` of 7 blocks every source, and an `ipl` of 0 admits levels 1 to 7.
- R6: Among eligible sources, the one with the highest level is presented, and `req_lvl` carries that level.
- R7: When eligible sources tie on the highest level, the lowest source index is presented.
- R8: `ack` while `req_valid` is 1 clears exactly the pending flag of the source shown on `req_idx`. `ack` while `req_valid` is 0 changes nothing.
- R9: If a request event and a clear (software or acknowledge) hit the same flag in the same cycle, the flag stays set.
- R10: With `rst` high at a clock edge, all pending flags clear, all levels become 0 and `req_valid`, `req_idx` and `req_lvl` become 0.
- R11: Writing a level leaves every pending flag unchanged. A pending source whose level is set to 0 and later restored is presented again without a new event.
- R12: The outputs are registered. After each edge they equal the selection over the pending flags and levels updated at that edge and the `gie`/`ipl` sampled at it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_evt | input | 8 | Per-source request event, one bit per source |
| gie | input | 1 | Global maskable interrupt enable |
| ipl | input | 3 | Core's current interrupt priority level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Source addressed by the write |
| cfg_lvl_we | input | 1 | Write `cfg_lvl` into the addressed level field |
| cfg_lvl | input | 3 | New level (0 disables) |
| cfg_pend_we | input | 1 | Write `cfg_pend_val` to the addressed pending flag |
| cfg_pend_val | input | 1 | 0 clears the flag, 1 is ignored |
| ack | input | 1 | Core acknowledge of the presented request |
| req_valid | output | 1 | A request is presented to the core |
| req_idx | output | 3 | Index of the presented source |
| req_lvl | output | 3 | Level of the presented source |

## Verification
A corrupted pending flag or level is seen at the ports one cycle later, provided the source is enabled and unmasked. It shows up as a missing or extra `req_valid`, or as a wrong `req_idx`/`req_lvl`.

A lost flag is detected by a later acknowledge that reveals the wrong next winner. Flags that cannot be seen directly are brought out by lowering `ipl` or raising levels until they compete, so every bit of state is observed through the selection.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int N_SRC = 8;
    localparam int LVL_W = 3;
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
        lvl_t lvl;
    } win_t;

    localparam win_t WIN_NONE = '{valid: 1'b0, idx: '0, lvl: '0};

    function automatic logic lvl_admitted(input lvl_t lvl, input lvl_t ipl);
        return (lvl > ipl);
    endfunction

    function automatic logic beats(input lvl_t cand, input logic have, input lvl_t best);
        return !have || (cand > best);
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_arb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      evt,
    input  logic                  cfg_we,
    input  idx_t                  cfg_idx,
    input  logic                  cfg_lvl_we,
    input  lvl_t                  cfg_lvl,
    input  logic                  cfg_pend_we,
    input  logic                  cfg_pend_val,
    input  logic                  ack_hit,
    input  idx_t                  ack_idx,
    output logic [N_SRC-1:0]      pend_d,
    output lvl_t [N_SRC-1:0]      lvl_d
);

    logic [N_SRC-1:0] pend_q;
    lvl_t [N_SRC-1:0] lvl_q;
    logic [N_SRC-1:0] sw_clr;
    logic [N_SRC-1:0] ack_clr;
    logic [N_SRC-1:0] lvl_wr;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_comb begin
            lvl_wr[i]  = cfg_we && cfg_lvl_we && (cfg_idx == idx_t'(i));
            sw_clr[i]  = cfg_we && cfg_pend_we && !cfg_pend_val && (cfg_idx == idx_t'(i));
            ack_clr[i] = ack_hit && (ack_idx == idx_t'(i));
            pend_d[i]  = evt[i] | (pend_q[i] & ~(sw_clr[i] | ack_clr[i]));
            lvl_d[i]   = lvl_wr[i] ? cfg_lvl : lvl_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
                lvl_q[i]  <= '0;
            end else begin
                pend_q[i] <= pend_d[i];
                lvl_q[i]  <= lvl_d[i];
            end
        end

        // R3: software access can only lower a flag
        a_r3_sw_never_sets: assert property (@(posedge clk) disable iff (rst)
            (!pend_q[i] && !evt[i]) |=> !pend_q[i]);

        // R9: an event always leaves the flag set
        a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> pend_q[i]);

        // R8: acknowledge without a new event clears the flag
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_hit && (ack_idx == idx_t'(i)) && !evt[i]) |=> !pend_q[i]);

        // R11: level writes keep the pending flag
        a_r11_lvl_indep: assert property (@(posedge clk) disable iff (rst)
            (lvl_wr[i] && !sw_clr[i] && !ack_clr[i] && pend_q[i]) |=> pend_q[i]);
    end

endmodule

// File: rtl/irq_elig.sv
module irq_elig
    import irq_arb_pkg::*;
(
    input  logic                  gie,
    input  lvl_t                  ipl,
    input  logic [N_SRC-1:0]      pend,
    input  lvl_t [N_SRC-1:0]      lvl,
    output logic [N_SRC-1:0]      elig
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
        assign elig[i] = gie && pend[i] && lvl_admitted(lvl[i], ipl);
    end

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
(
    input  logic [N_SRC-1:0]      elig,
    input  lvl_t [N_SRC-1:0]      lvl,
    output win_t                  win
);

    always_comb begin
        win = WIN_NONE;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && beats(lvl[i], win.valid, win.lvl)) begin
                win.valid = 1'b1;
                win.idx   = idx_t'(i);
                win.lvl   = lvl[i];
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SRC-1:0]       irq_evt,
    input  logic                   gie,
    input  logic [LVL_W-1:0]       ipl,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic                   cfg_lvl_we,
    input  logic [LVL_W-1:0]       cfg_lvl,
    input  logic                   cfg_pend_we,
    input  logic                   cfg_pend_val,
    input  logic                   ack,
    output logic                   req_valid,
    output logic [IDX_W-1:0]       req_idx,
    output logic [LVL_W-1:0]       req_lvl
);

    logic [N_SRC-1:0] pend_d;
    lvl_t [N_SRC-1:0] lvl_d;
    logic [N_SRC-1:0] elig;
    win_t             win_d;
    win_t             win_q;
    logic             ack_hit;

    assign ack_hit = ack && win_q.valid;

    irq_pend_bank u_bank (
        .clk          (clk),
        .rst          (rst),
        .evt          (irq_evt),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_lvl_we   (cfg_lvl_we),
        .cfg_lvl      (cfg_lvl),
        .cfg_pend_we  (cfg_pend_we),
        .cfg_pend_val (cfg_pend_val),
        .ack_hit      (ack_hit),
        .ack_idx      (win_q.idx),
        .pend_d       (pend_d),
        .lvl_d        (lvl_d)
    );

    irq_elig u_elig (
        .gie  (gie),
        .ipl  (ipl),
        .pend (pend_d),
        .lvl  (lvl_d),
        .elig (elig)
    );

    irq_select u_sel (
        .elig (elig),
        .lvl  (lvl_d),
        .win  (win_d)
    );

    always_ff @(posedge clk) begin
        if (rst) win_q <= WIN_NONE;
        else     win_q <= win_d;
    end

    assign req_valid = win_q.valid;
    assign req_idx   = win_q.idx;
    assign req_lvl   = win_q.lvl;

    // R1: nothing presented after an edge with the enable low
    a_r1_gie_gates: assert property (@(posedge clk) disable iff (rst)
        !gie |=> !req_valid);

    // R5: presented level is above the IPL sampled at the edge before
    a_r5_above_ipl: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_lvl > $past(ipl)));

    // R4: a disabled level is never presented
    a_r4_nonzero_lvl: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_lvl != '0));

    // R10: idle output is fully zero
    a_r10_idle_zero: assert property (@(posedge clk)
        !req_valid |-> (req_idx == '0 && req_lvl == '0));

endmodule

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] irq_evt;
    logic gie;
    logic [2:0] ipl;
    logic cfg_we, cfg_lvl_we, cfg_pend_we, cfg_pend_val, ack;
    logic [2:0] cfg_idx, cfg_lvl;
    logic req_valid;
    logic [2:0] req_idx, req_lvl;

    always #2 clk = ~clk;

    irq_prio_arbiter i_irq_prio_arbiter (
        .clk(clk), .rst(rst), .irq_evt(irq_evt), .gie(gie), .ipl(ipl),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_lvl_we(cfg_lvl_we), .cfg_lvl(cfg_lvl),
        .cfg_pend_we(cfg_pend_we), .cfg_pend_val(cfg_pend_val), .ack(ack),
        .req_valid(req_valid), .req_idx(req_idx), .req_lvl(req_lvl)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit       m_pend [N];
    bit [2:0] m_lvl  [N];
    bit       e_valid;
    bit [2:0] e_idx, e_lvl;

    function automatic void select_model(input bit g, input bit [2:0] p);
        e_valid = 0; e_idx = 0; e_lvl = 0;
        for (int i = 0; i < N; i++) begin
            if (g && m_pend[i] && m_lvl[i] > p && (!e_valid || m_lvl[i] > e_lvl)) begin
                e_valid = 1; e_idx = 3'(i); e_lvl = m_lvl[i];
            end
        end
    endfunction

    task automatic idle_inputs();
        irq_evt = '0; cfg_we = 0; cfg_lvl_we = 0; cfg_lvl = 0; cfg_pend_we = 0;
        cfg_pend_val = 0; cfg_idx = 0; ack = 0;
    endtask

    task automatic check(input string tag);
        checks++;
        if (req_valid !== e_valid || (e_valid && (req_idx !== e_idx || req_lvl !== e_lvl))
            || (!e_valid && (req_idx !== 3'd0 || req_lvl !== 3'd0))) begin
            errors++;
            $display("FAIL %s: got valid=%0b idx=%0d lvl=%0d, expected valid=%0b idx=%0d lvl=%0d",
                     tag, req_valid, req_idx, req_lvl, e_valid, e_idx, e_lvl);
        end
    endtask

    // one clock: model update mirrors the edge, then sample at negedge
    task automatic cycle(input string tag);
        bit clr;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            clr = (ack && e_valid && e_idx == 3'(i)) ||
                  (cfg_we && cfg_pend_we && !cfg_pend_val && cfg_idx == 3'(i));
            if (clr) m_pend[i] = 0;
            if (cfg_we && cfg_lvl_we && cfg_idx == 3'(i)) m_lvl[i] = cfg_lvl;
            if (irq_evt[i]) m_pend[i] = 1;
        end
        select_model(gie, ipl);
        @(negedge clk);
        check(tag);
        idle_inputs();
    endtask

    task automatic set_lvl(input int s, input int l, input string tag);
        cfg_we = 1; cfg_lvl_we = 1; cfg_idx = 3'(s); cfg_lvl = 3'(l);
        cycle(tag);
    endtask

    task automatic sw_pend(input int s, input bit v, input string tag);
        cfg_we = 1; cfg_pend_we = 1; cfg_idx = 3'(s); cfg_pend_val = v;
        cycle(tag);
    endtask

    task automatic fire(input int s, input string tag);
        irq_evt = '0; irq_evt[s] = 1'b1;
        cycle(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5A5A));
        idle_inputs(); gie = 1; ipl = 0; rst = 1;
        for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_lvl[i] = 0; end
        e_valid = 0; e_idx = 0; e_lvl = 0;
        irq_evt = '1;
        repeat (3) @(negedge clk);
        idle_inputs();
        @(negedge clk);
        rst = 0;
        check("R10 reset state");
        fire(2, "R10 level zero after reset ignores event");
        sw_pend(2, 0, "R3 clear");

        // R2 / R4: event with level set
        set_lvl(3, 5, "R4 level write no pending");
        fire(3, "R2 event presented");
        cycle("R2 held");
        gie = 0; cycle("R1 gie low masks");
        gie = 1; cycle("R1 gie restore");
        // R5 thresholds
        ipl = 5; cycle("R5 equal level blocked");
        ipl = 4; cycle("R5 lower ipl admits");
        set_lvl(3, 7, "R4 level 7");
        ipl = 7; cycle("R5 ipl 7 blocks all");
        ipl = 0;
        // R11 level zero then restore
        set_lvl(3, 0, "R4 level 0 disables");
        set_lvl(3, 5, "R11 pending survives level write");
        // R3 software write of 1 has no effect
        set_lvl(6, 6, "R3 setup");
        sw_pend(6, 1, "R3 write one ignored");
        sw_pend(3, 0, "R3 write zero clears");
        // R6 highest wins
        set_lvl(1, 2, "R6 setup");
        fire(1, "R6 single low");
        fire(6, "R6 higher level wins");
        // R7 tie
        set_lvl(1, 6, "R7 tie lowest index");
        // R8 ack
        ack = 1; cycle("R8 ack clears presented");
        ack = 1; cycle("R8 ack clears next");
        ack = 1; cycle("R8 ack while idle ignored");
        // R9 event vs clears
        fire(4, "R9 setup event");
        set_lvl(4, 3, "R9 setup level");
        irq_evt[4] = 1; cfg_we = 1; cfg_pend_we = 1; cfg_pend_val = 0; cfg_idx = 4;
        cycle("R9 event beats sw clear");
        irq_evt[4] = 1; ack = 1; cycle("R9 event beats ack");
        ack = 1; cycle("R8 final ack");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            irq_evt = N'($urandom & $urandom & $urandom);
            gie = ($urandom % 10) != 0;
            ipl = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 3);
            if ($urandom % 4 == 0) begin
                cfg_we = 1; cfg_idx = 3'($urandom);
                cfg_lvl_we = 1'($urandom); cfg_lvl = 3'($urandom);
                cfg_pend_we = 1'($urandom); cfg_pend_val = 1'($urandom);
            end
            ack = ($urandom % 2 == 0);
            cycle("R12 random");
        end

        rst = 1; irq_evt = '1;
        for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_lvl[i] = 0; end
        @(negedge clk); idle_inputs(); @(negedge clk); rst = 0;
        e_valid = 0; e_idx = 0; e_lvl = 0;
        check("R10 reset after traffic");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule